// File: doc/BRIEF.md
# SHA-2 Block Compression Engine

This block runs the SHA-2 compression function on one pre-padded message block at a time. It serves the whole SHA-2 family. The 256-class variants use 32-bit words, 64 rounds and 512-bit blocks. The 512-class variants use 64-bit words, 80 rounds and 1024-bit blocks. Software pads the message and appends its length. It then presents the blocks one after another, each with a single-cycle `start` and a flag that marks the first block of a message.

The engine runs one round per clock. A 16-word sliding window produces the message schedule on the fly. A working state of eight words changes each round. A separate hash state of eight words takes in the working state at the end of every block. SHA-224, SHA-384, SHA-512/224 and SHA-512/256 use the same round logic as their parent algorithm. They differ only in their initial values and in how much of the hash state appears on the digest output.

Top module: `sha2_core`

## Requirements
- R1: After reset `busy` and `done` are low and `digest` is all zero.
- R2: When `start` is high and `busy` is low, a block begins. `busy` is then high for exactly 64 cycles for mode codes 0 and 1, and for exactly 80 cycles for all other codes. `done` is high for one cycle, in the cycle in which `busy` has just fallen.
- R3: The mode code selects the variant: 0 SHA-224, 1 SHA-256, 2 SHA-384, 3 SHA-512, 4 SHA-512/224, 5 SHA-512/256. For the padded one-block message "abc" with the first-block flag set, each variant yields its standard digest.
- R4: `digest` is left-aligned. The leftmost hash word sits at the top, and the bits past the variant's length are zero. The lengths are 224, 256, 384, 512, 224 and 256 bits for codes 0 to 5. SHA-512/224 keeps only the upper half of its fourth word.
- R5: With the first-block flag set, the hash state starts from the selected variant's initial values. With it clear, compression continues from the hash state left by the previous block, so two-block messages give the standard digests.
- R6: In 256-class modes only `block[1023:512]` is read, with word 0 at `block[1023:992]`. The lower half has no effect. In 512-class modes word 0 is `block[1023:960]`.
- R7: A `start` pulse while `busy` is high is ignored. The block in progress keeps its length and its digest.
- R8: `mode`, `first_blk` and `block` are sampled only in the accepting cycle. Changes to them while `busy` is high do not change the result.
- R9: The unused mode codes 6 and 7 run as SHA-512.
- R10: While idle, `digest` holds its value until the next accepted `start`, whatever `mode` or `block` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin compressing `block` when idle |
| mode | input | 3 | Variant code (see R3, R9) |
| first_blk | input | 1 | Block is the first of a message; load initial values |
| block | input | 1024 | Padded message block, word 0 at the top |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the hash state update |
| digest | output | 512 | Truncated, left-aligned hash value |

## Verification
The engine has no tunable configuration. Word, block and window sizes follow from the algorithm, so the bench builds it with the package defaults. With those defaults, every one of the eight mode codes can be swept. This covers both round counts, all four truncation lengths, including the half-word cut of SHA-512/224, and both unused codes. Two-block messages in each word width test the carry of the hash state between blocks. One run changes every input in the middle of a block to show that those inputs are sampled only at the start.

// File: rtl/sha2_pkg.sv
// sha2_pkg: shared sizes, variant type and word-level helpers for the SHA-2
// engine. Words are always carried 64 bits wide; in 256-class modes only the
// low 32 bits are meaningful and the upper half is held at zero.
package sha2_pkg;
    localparam int WORD_W        = 64;
    localparam int HALF_W        = WORD_W / 2;
    localparam int BLOCK_W       = 1024;
    localparam int DIGEST_W      = 512;
    localparam int N_WIN         = 16;
    localparam int N_STATE       = 8;
    localparam int ROUNDS_NARROW = 64;
    localparam int ROUNDS_WIDE   = 80;
    localparam int RND_W         = $clog2(ROUNDS_WIDE);
    localparam int N_ROOTS       = 2 * N_STATE;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        V_224     = 3'd0,
        V_256     = 3'd1,
        V_384     = 3'd2,
        V_512     = 3'd3,
        V_512_224 = 3'd4,
        V_512_256 = 3'd5
    } variant_e;

    // Map the raw mode code onto a variant; spare codes run as SHA-512.
    function automatic variant_e decode_mode(logic [2:0] m);
        case (m)
            3'd0:    return V_224;
            3'd1:    return V_256;
            3'd2:    return V_384;
            3'd4:    return V_512_224;
            3'd5:    return V_512_256;
            default: return V_512;
        endcase
    endfunction

    // True for the variants built on 64-bit words.
    function automatic logic is_wide(variant_e v);
        return !(v == V_224 || v == V_256);
    endfunction

    // Number of digest bits the variant exposes.
    function automatic int unsigned digest_len(variant_e v);
        case (v)
            V_224, V_512_224: return 224;
            V_256, V_512_256: return 256;
            V_384:            return 384;
            default:          return 512;
        endcase
    endfunction

    // n-th prime, counting from zero (used only with constant arguments).
    function automatic int unsigned nth_prime(int unsigned n);
        int unsigned found;
        int unsigned res;
        logic        is_p;
        found = 0;
        res   = 2;
        for (int unsigned c = 2; c < 512; c++) begin
            is_p = 1'b1;
            for (int unsigned d = 2; d * d <= c; d++)
                if (c % d == 0) is_p = 1'b0;
            if (is_p) begin
                if (found == n) res = c;
                found++;
            end
        end
        return res;
    endfunction

    // First 64 fractional bits of the square (deg=2) or cube (deg=3) root of p.
    function automatic word_t root_frac(int unsigned p, int unsigned deg);
        logic [255:0] target;
        logic [255:0] cand;
        logic [255:0] pw;
        logic [67:0]  r;
        target = 256'(p) << (WORD_W * deg);
        r = '0;
        for (int b = 67; b >= 0; b--) begin
            cand = 256'(r | (68'(1) << b));
            pw   = cand * cand;
            if (deg == 3) pw = pw * cand;
            if (pw <= target) r = cand[67:0];
        end
        return r[WORD_W-1:0];
    endfunction

    function automatic word_t wmask(word_t x, logic wide);
        return wide ? x : {{HALF_W{1'b0}}, x[HALF_W-1:0]};
    endfunction

    function automatic word_t rotr(word_t x, int unsigned n, logic wide);
        logic [HALF_W-1:0] lo;
        lo = x[HALF_W-1:0];
        if (wide) return (x >> n) | (x << (WORD_W - n));
        return {{HALF_W{1'b0}}, (lo >> n) | (lo << (HALF_W - n))};
    endfunction

    function automatic word_t shr(word_t x, int unsigned n, logic wide);
        return wide ? (x >> n) : {{HALF_W{1'b0}}, x[HALF_W-1:0] >> n};
    endfunction

    function automatic word_t big_s0(word_t x, logic wide);
        return wide ? (rotr(x, 28, 1'b1) ^ rotr(x, 34, 1'b1) ^ rotr(x, 39, 1'b1))
                    : (rotr(x, 2, 1'b0) ^ rotr(x, 13, 1'b0) ^ rotr(x, 22, 1'b0));
    endfunction

    function automatic word_t big_s1(word_t x, logic wide);
        return wide ? (rotr(x, 14, 1'b1) ^ rotr(x, 18, 1'b1) ^ rotr(x, 41, 1'b1))
                    : (rotr(x, 6, 1'b0) ^ rotr(x, 11, 1'b0) ^ rotr(x, 25, 1'b0));
    endfunction

    function automatic word_t sml_s0(word_t x, logic wide);
        return wide ? (rotr(x, 1, 1'b1) ^ rotr(x, 8, 1'b1) ^ shr(x, 7, 1'b1))
                    : (rotr(x, 7, 1'b0) ^ rotr(x, 18, 1'b0) ^ shr(x, 3, 1'b0));
    endfunction

    function automatic word_t sml_s1(word_t x, logic wide);
        return wide ? (rotr(x, 19, 1'b1) ^ rotr(x, 61, 1'b1) ^ shr(x, 6, 1'b1))
                    : (rotr(x, 17, 1'b0) ^ rotr(x, 19, 1'b0) ^ shr(x, 10, 1'b0));
    endfunction
endpackage

// File: rtl/sha2_round_k.sv
// sha2_round_k: round constant for round idx. The constants are the cube-root
// fractions of the first ROUNDS_WIDE primes; narrow modes use the upper half.
// Assumes idx < ROUNDS_WIDE whenever the value is used.
module sha2_round_k
    import sha2_pkg::*;
(
    input  logic [RND_W-1:0] idx,
    input  logic             wide,
    output word_t            k
);
    word_t tab [ROUNDS_WIDE];

    for (genvar g = 0; g < ROUNDS_WIDE; g++) begin : g_k
        assign tab[g] = root_frac(nth_prime(g), 3);
    end

    // Pick the entry and cut it to the active word width.
    always_comb begin
        k = wide ? tab[idx] : {{HALF_W{1'b0}}, tab[idx][WORD_W-1:HALF_W]};
    end
endmodule

// File: rtl/sha2_iv.sv
// sha2_iv: initial hash values of the selected variant. SHA-256/512 and
// SHA-224/384 values come from square-root fractions of the first sixteen
// primes; the two SHA-512/t sets are fixed tables.
module sha2_iv
    import sha2_pkg::*;
(
    input  variant_e                 var_sel,
    output word_t [N_STATE-1:0]      iv
);
    localparam word_t [N_STATE-1:0] IV_T224 = {
        64'h1112e6ad91d692a1, 64'h3f9d85a86a1d36c8, 64'h77e36f7304c48942, 64'h0f6d2b697bd44da8,
        64'h679dd514582f9fcf, 64'h1dfab7ae32ff9c82, 64'h73e1996689dcd4d6, 64'h8c3d37c819544da2};
    localparam word_t [N_STATE-1:0] IV_T256 = {
        64'h0eb72ddc81c52ca2, 64'h2b0199fc2c85b8aa, 64'hbe5e1e2553863992, 64'h96283ee2a88effe3,
        64'h963877195940eabd, 64'h2393b86b6f53b151, 64'h9f555fa3c84c64c2, 64'h22312194fc2bf72c};

    word_t sq [N_ROOTS];

    for (genvar g = 0; g < N_ROOTS; g++) begin : g_sq
        assign sq[g] = root_frac(nth_prime(g), 2);
    end

    // Assemble the eight starting words for the chosen variant.
    always_comb begin
        for (int i = 0; i < N_STATE; i++) begin
            case (var_sel)
                V_256:     iv[i] = {{HALF_W{1'b0}}, sq[i][WORD_W-1:HALF_W]};
                V_224:     iv[i] = {{HALF_W{1'b0}}, sq[N_STATE+i][HALF_W-1:0]};
                V_384:     iv[i] = sq[N_STATE+i];
                V_512_224: iv[i] = IV_T224[i];
                V_512_256: iv[i] = IV_T256[i];
                default:   iv[i] = sq[i];
            endcase
        end
    end
endmodule

// File: rtl/sha2_schedule.sv
// sha2_schedule: 16-word sliding message window. On load it captures the
// block (32- or 64-bit words, word 0 at the top); on each advance it drops
// the oldest word and appends the next schedule word. w_cur is W[t].
module sha2_schedule
    import sha2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic               wide_ld,
    input  logic               wide_run,
    input  logic [BLOCK_W-1:0] blk,
    output word_t              w_cur
);
    word_t [N_WIN-1:0] win_q;
    word_t             w_new;

    // Next schedule word from the window taps.
    always_comb begin
        w_new = wmask(sml_s1(win_q[14], wide_run) + win_q[9]
                      + sml_s0(win_q[1], wide_run) + win_q[0], wide_run);
    end

    // Load the block or slide the window one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (load) begin
            for (int i = 0; i < N_WIN; i++)
                win_q[i] <= wide_ld ? blk[BLOCK_W-1-WORD_W*i -: WORD_W]
                                    : {{HALF_W{1'b0}}, blk[BLOCK_W-1-HALF_W*i -: HALF_W]};
        end else if (adv) begin
            win_q <= {w_new, win_q[N_WIN-1:1]};
        end
    end

    assign w_cur = win_q[0];

    // R2
    slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (win_q[0] == $past(win_q[1])));
endmodule

// File: rtl/sha2_round.sv
// sha2_round: one combinational SHA-2 round on the eight-word working state
// (index 0 is a, 7 is h). Assumes inputs have zero upper halves in narrow mode.
module sha2_round
    import sha2_pkg::*;
(
    input  word_t [N_STATE-1:0] st,
    input  word_t               k,
    input  word_t               w,
    input  logic                wide,
    output word_t [N_STATE-1:0] st_nxt
);
    word_t t1;
    word_t t2;
    word_t ch;
    word_t maj;

    // Round arithmetic with results folded to the active word width.
    always_comb begin
        ch  = (st[4] & st[5]) ^ (~st[4] & st[6]);
        maj = (st[0] & st[1]) ^ (st[0] & st[2]) ^ (st[1] & st[2]);
        t1  = wmask(st[7] + big_s1(st[4], wide) + wmask(ch, wide) + k + w, wide);
        t2  = wmask(big_s0(st[0], wide) + maj, wide);
        st_nxt[0] = wmask(t1 + t2, wide);
        st_nxt[1] = st[0];
        st_nxt[2] = st[1];
        st_nxt[3] = st[2];
        st_nxt[4] = wmask(st[3] + t1, wide);
        st_nxt[5] = st[4];
        st_nxt[6] = st[5];
        st_nxt[7] = st[6];
    end
endmodule

// File: rtl/sha2_core.sv
// sha2_core: SHA-2 compression engine for all six variants. A start while
// idle latches the variant, loads the schedule window and seeds the working
// state; one round runs per clock, and the last round's result is added into
// the hash state on the same edge that raises done. Assumes padded blocks.
module sha2_core
    import sha2_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         mode,
    input  logic               first_blk,
    input  logic [BLOCK_W-1:0] block,
    output logic               busy,
    output logic               done,
    output logic [DIGEST_W-1:0] digest
);
    variant_e            var_in;
    variant_e            var_q;
    logic                wide_in;
    logic                wide_q;
    logic                accept;
    logic                last_rnd;
    logic                busy_q;
    logic                done_q;
    logic [RND_W-1:0]    rnd_q;
    word_t [N_STATE-1:0] hash_q;
    word_t [N_STATE-1:0] work_q;
    word_t [N_STATE-1:0] work_nxt;
    word_t [N_STATE-1:0] iv;
    word_t               k_cur;
    word_t               w_cur;
    logic [DIGEST_W-1:0] full;
    logic [DIGEST_W-1:0] keep;

    // Input decode and round bookkeeping.
    always_comb begin
        var_in   = decode_mode(mode);
        wide_in  = is_wide(var_in);
        accept   = start && !busy_q;
        last_rnd = (rnd_q == RND_W'(wide_q ? ROUNDS_WIDE - 1 : ROUNDS_NARROW - 1));
    end

    sha2_iv u_iv (
        .var_sel (var_in),
        .iv      (iv)
    );

    sha2_round_k u_k (
        .idx  (rnd_q),
        .wide (wide_q),
        .k    (k_cur)
    );

    sha2_schedule u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .adv      (busy_q),
        .wide_ld  (wide_in),
        .wide_run (wide_q),
        .blk      (block),
        .w_cur    (w_cur)
    );

    sha2_round u_round (
        .st     (work_q),
        .k      (k_cur),
        .w      (w_cur),
        .wide   (wide_q),
        .st_nxt (work_nxt)
    );

    // Control, working state and hash accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
            var_q  <= V_224;
            wide_q <= 1'b0;
            hash_q <= '0;
            work_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
                var_q  <= var_in;
                wide_q <= wide_in;
                if (first_blk) begin
                    hash_q <= iv;
                    work_q <= iv;
                end else begin
                    work_q <= hash_q;
                end
            end else if (busy_q) begin
                work_q <= work_nxt;
                rnd_q  <= rnd_q + 1'b1;
                if (last_rnd) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    for (int i = 0; i < N_STATE; i++)
                        hash_q[i] <= wmask(hash_q[i] + work_nxt[i], wide_q);
                end
            end
        end
    end

    // Left-align the hash words and keep only the variant's digest bits.
    always_comb begin
        full = '0;
        for (int i = 0; i < N_STATE; i++) begin
            if (wide_q) full[DIGEST_W-1-WORD_W*i -: WORD_W] = hash_q[i];
            else        full[DIGEST_W-1-HALF_W*i -: HALF_W] = hash_q[i][HALF_W-1:0];
        end
        keep   = ~({DIGEST_W{1'b1}} >> digest_len(var_q));
        digest = full & keep;
    end

    assign busy = busy_q;
    assign done = done_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_rnd) |=> (busy && $stable(hash_q) && $stable(var_q)));
    // R10
    idle_digest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(digest));
endmodule

// File: tb/tb_sha2_core.sv
`timescale 1ns/1ps
module tb_sha2_core;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic          first_blk = 1'b0;
    logic [1023:0] block = '0;
    logic          busy;
    logic          done;
    logic [511:0]  digest;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sha2_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .first_blk (first_blk),
        .block     (block),
        .busy      (busy),
        .done      (done),
        .digest    (digest)
    );

    localparam logic [447:0] MSG_N = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
    localparam logic [895:0] MSG_W = "abcdefghbcdefghicdefghijdefghijkefghijklfghijklmghijklmnhijklmnoijklmnopjklmnopqklmnopqrlmnopqrsmnopqrstnopqrstu";
    localparam logic [511:0] JUNK  = {16{32'hdeadbeef}};

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] exp_abc(input int code);
        case (code)
            0: return {224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7, 288'b0};
            1: return {256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad, 256'b0};
            2: return {384'hcb00753f45a35e8bb5a03d699ac65007272c32ab0eded1631a8b605a43ff5bed8086072ba1e7cc2358baeca134c825a7, 128'b0};
            4: return {224'h4634270f707b6a54daae7530460842e20e37ed265ceee9a43e8924aa, 288'b0};
            5: return {256'h53048e2681941ef99b2e29b76b4c7dabe4c2d0c634fc6d46e0e2f13107e7af23, 256'b0};
            default: return 512'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f;
        endcase
    endfunction

    function automatic logic [1023:0] abc_block(input int code);
        if (code < 2) return {24'h616263, 8'h80, 416'b0, 64'd24, JUNK};
        return {24'h616263, 8'h80, 864'b0, 128'd24};
    endfunction

    // Issue one block; count busy cycles and report done at the fall of busy.
    task automatic run_block(input logic [2:0] m, input logic f, input logic [1023:0] blk,
                             input bit disturb, output int cyc, output logic dn);
        @(negedge clk);
        mode = m; first_blk = f; block = blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 200) begin
            cyc++;
            if (disturb && cyc == 3) begin
                start = 1'b1; mode = ~m; first_blk = ~f; block = ~blk;
            end
            @(negedge clk);
        end
        start = 1'b0;
        dn = done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic dn;
        logic [511:0] held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 512'(busy), 512'(0));
        chk("R1 done", 512'(done), 512'(0));
        chk("R1 digest", digest, '0);

        // R3 R4 R6 R9: "abc" for every code, junk in unused low half for narrow codes
        for (int c = 0; c < 8; c++) begin
            run_block(3'(c), 1'b1, abc_block(c), 1'b0, cyc, dn);
            chk($sformatf("R2 rounds code %0d", c), 512'(cyc), 512'(c < 2 ? 64 : 80));
            chk($sformatf("R2 done code %0d", c), 512'(dn), 512'(1));
            chk($sformatf("R3 R4 R6 R9 digest code %0d", c), digest, exp_abc(c));
            @(negedge clk);
            chk($sformatf("R2 done drop code %0d", c), 512'(done), 512'(0));
        end

        // R5: two-block SHA-256 message
        run_block(3'd1, 1'b1, {MSG_N, 8'h80, 56'b0, JUNK}, 1'b0, cyc, dn);
        run_block(3'd1, 1'b0, {448'b0, 64'd448, 512'b0}, 1'b0, cyc, dn);
        chk("R5 two-block 256", digest,
            {256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1, 256'b0});

        // R5: two-block SHA-512 message
        run_block(3'd3, 1'b1, {MSG_W, 8'h80, 120'b0}, 1'b0, cyc, dn);
        run_block(3'd3, 1'b0, {896'b0, 128'd896}, 1'b0, cyc, dn);
        chk("R5 two-block 512", digest,
            512'h8e959b75dae313da8cf4f72814fc143f8f7779c6eb9f7fa17299aeadb6889018501d289e4900f7e4331b99dec4b5433ac7d329eeb6dd26545e96e55b874be909);

        // R7 R8: restart attempt and input changes mid-block
        run_block(3'd2, 1'b1, abc_block(2), 1'b1, cyc, dn);
        chk("R7 rounds unchanged", 512'(cyc), 512'(80));
        chk("R7 done", 512'(dn), 512'(1));
        chk("R8 digest unchanged", digest, exp_abc(2));
        @(negedge clk);
        chk("R7 no second block", 512'(busy), 512'(0));

        // R10: idle input changes leave the digest alone
        held = digest;
        mode = 3'd1; block = JUNK; first_blk = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 idle digest hold", digest, held);
        chk("R10 idle stays idle", 512'(busy), 512'(0));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule